// File: doc/BRIEF.md
# Subclock Idle Wake-Up Controller

This block decides when the CPU clock may be stopped for a low-power idle state in which only the slow subclock keeps running, and when it may run again. Software selects a power mode and writes a stop request. After a fixed padding of cycles the block gates the CPU clock. Stored state is kept while the clock is gated, because the block only drops an enable. The block runs on the subclock. Request and reset inputs from other domains pass through two-stage synchronizers before the block uses them.

Idle ends when one of these arrives: a non-maskable request, an unmasked maskable request, or any reset source. A release mask bit for each class can keep non-maskable or maskable requests from ending idle at all. Ending idle and acknowledging the request are separate decisions. Any maskable request that may wake the block ends idle. It is only marked for acknowledge if it is more urgent than the routine already in service. A release by interrupt returns the block to subclock run mode after a 12-cycle stabilization wait. A release by reset holds the clock off until the reset sources drop, and then goes through the same wait.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After `rst_n` deasserts, `clk_mode` is 3'b000 (run), `cpu_clk_en` is 1, and `wake_pulse` and `ack_ok` are 0.
- R2: A stop write moves the block out of run mode only when `pmode_sel` is 2'b00 or 2'b10, that is, when bit 0 is 0. With 2'b01 or 2'b11 the block stays in run mode with the clock enabled.
- R3: An accepted stop write puts the block in mode 3'b001 (entry padding) for ENTRY_DLY cycles with `cpu_clk_en` still 1. On the ENTRY_DLY+1-th edge after the write, the block enters mode 3'b010 (idle) and `cpu_clk_en` is 0.
- R4: In idle, either of two inputs ends idle: `nmi_req` with `nmi_blk`=0, or any bit of `irq_req` with `int_blk`=0. The request input must rise 3 edges before the block leaves idle, because 2 of those edges are synchronizer stages. A request whose class blocking bit is 1 leaves the block idle with the clock off.
- R5: After a release, the block stays in mode 3'b011 (stabilizing) for exactly STAB_CYC cycles and then returns to mode 3'b000. `wake_pulse` is high for exactly the one cycle in which `cpu_clk_en` first returns to 1.
- R6: On a release, `ack_ok` becomes 1 if any of these holds: the release came from a non-maskable request, `in_service` is 0, or the most urgent active request beats `isr_prio`. A lower priority value is more urgent, so the request beats `isr_prio` when its value is strictly smaller. Otherwise `ack_ok` becomes 0.
- R7: If a wake condition is already present when entry padding ends, the block returns directly to mode 3'b000 without ever dropping `cpu_clk_en`. `ack_ok` is then set by the rule in R6.
- R8: Any bit of `rst_src` overrides every other input in every mode. If the bit is held for two or more cycles, the block enters mode 3'b100 (reset hold) with `cpu_clk_en`=0 and `ack_ok`=0. When all bits drop, the block stabilizes as in R5 and then runs.
- R9: `ack_ok` keeps its value while running and is cleared by the next accepted stop write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pmode_sel | input | 2 | Power-mode select; bit 0 must be 0 to allow this idle state |
| stop_wr | input | 1 | One-cycle pulse: software wrote the stop request |
| nmi_req | input | 1 | Non-maskable request, asynchronous |
| nmi_blk | input | 1 | 1 = non-maskable request may not end idle |
| irq_req | input | N_IRQ | Maskable requests (already unmasked by the interrupt controller), asynchronous |
| irq_prio | input | N_IRQ*PRIO_W | Priority value per request, field i at [i*PRIO_W +: PRIO_W] |
| int_blk | input | 1 | 1 = maskable requests may not end idle |
| in_service | input | 1 | A service routine is active |
| isr_prio | input | PRIO_W | Priority value of the routine in service |
| rst_src | input | N_RST | Reset sources (pin, watchdog, low voltage, clock monitor), asynchronous |
| cpu_clk_en | output | 1 | Clock enable for CPU, memory and ordinary peripherals |
| wake_pulse | output | 1 | One-cycle pulse when the clock enable returns |
| ack_ok | output | 1 | The releasing request may be acknowledged |
| clk_mode | output | 3 | 000 run, 001 entry padding, 010 idle, 011 stabilizing, 100 reset hold |

## Verification
Each result has its own latency, counted in edges from the negative edge where the stimulus is driven. A stop write shows entry padding after 1 edge and idle after ENTRY_DLY+1 edges. A synchronized request or reset source changes the mode after 3 edges. A release reaches run mode 3+STAB_CYC edges after the request. Removing a blocking bit while a request is held takes 1+STAB_CYC edges. The bench samples on negative edges after exactly these counts, and also checks the cycle just before each change, so a result that arrives one cycle early or late fails. Priority acknowledge is swept over every pair of request and in-service priority values.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

    typedef enum logic [2:0] {
        MODE_RUN   = 3'b000,
        MODE_ARM   = 3'b001,
        MODE_IDLE  = 3'b010,
        MODE_STAB  = 3'b011,
        MODE_RHOLD = 3'b100
    } mode_e;

    typedef struct packed {
        mode_e      mode;
        logic [7:0] cnt;
        logic       ack;
        logic       pulse;
    } ctl_s;

endpackage

// File: rtl/idle_wake_sync.sv
module idle_wake_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= din[g];
                s2_q <= s1_q;
            end
        end
        assign dout[g] = s2_q;
    end
endmodule

// File: rtl/idle_wake_arb.sv
module idle_wake_arb #(
    parameter int N  = 4,
    parameter int PW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            any,
    output logic [PW-1:0]   best
);
    always_comb begin
        any  = 1'b0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || prio[i*PW +: PW] < best)) begin
                best = prio[i*PW +: PW];
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
    import idle_wake_pkg::*;
#(
    parameter int N_IRQ     = 4,
    parameter int PRIO_W    = 3,
    parameter int N_RST     = 4,
    parameter int ENTRY_DLY = 5,
    parameter int STAB_CYC  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              pmode_sel,
    input  logic                    stop_wr,
    input  logic                    nmi_req,
    input  logic                    nmi_blk,
    input  logic [N_IRQ-1:0]        irq_req,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                    int_blk,
    input  logic                    in_service,
    input  logic [PRIO_W-1:0]       isr_prio,
    input  logic [N_RST-1:0]        rst_src,
    output logic                    cpu_clk_en,
    output logic                    wake_pulse,
    output logic                    ack_ok,
    output logic [2:0]              clk_mode
);
    localparam int          SYNC_W   = N_IRQ + N_RST + 1;
    localparam logic [7:0]  ENT_LAST = 8'(ENTRY_DLY - 1);
    localparam logic [7:0]  STB_LAST = 8'(STAB_CYC - 1);

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [N_IRQ-1:0]  irq_s;
    logic [N_RST-1:0]  rst_s;
    logic              nmi_s;

    assign sync_in = {rst_src, irq_req, nmi_req};

    idle_wake_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_out)
    );

    assign nmi_s = sync_out[0];
    assign irq_s = sync_out[N_IRQ:1];
    assign rst_s = sync_out[SYNC_W-1:N_IRQ+1];

    logic              irq_any;
    logic [PRIO_W-1:0] irq_best;

    idle_wake_arb #(.N(N_IRQ), .PW(PRIO_W)) u_arb (
        .req  (irq_s),
        .prio (irq_prio),
        .any  (irq_any),
        .best (irq_best)
    );

    logic rst_any, nmi_wake, irq_wake, wake_any, ack_now;

    assign rst_any  = |rst_s;
    assign nmi_wake = nmi_s & ~nmi_blk;
    assign irq_wake = irq_any & ~int_blk;
    assign wake_any = nmi_wake | irq_wake;
    assign ack_now  = nmi_wake | (irq_wake & (~in_service | (irq_best < isr_prio)));

    ctl_s d, q;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (rst_any) begin
            d.mode = MODE_RHOLD;
            d.cnt  = '0;
            d.ack  = 1'b0;
        end else begin
            unique case (q.mode)
                MODE_RUN: begin
                    if (stop_wr && !pmode_sel[0]) begin
                        d.mode = MODE_ARM;
                        d.cnt  = '0;
                        d.ack  = 1'b0;
                    end
                end
                MODE_ARM: begin
                    if (q.cnt == ENT_LAST) begin
                        d.cnt = '0;
                        if (wake_any) begin
                            d.mode = MODE_RUN;
                            d.ack  = ack_now;
                        end else begin
                            d.mode = MODE_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 8'd1;
                    end
                end
                MODE_IDLE: begin
                    if (wake_any) begin
                        d.mode = MODE_STAB;
                        d.cnt  = '0;
                        d.ack  = ack_now;
                    end
                end
                MODE_STAB: begin
                    if (q.cnt == STB_LAST) begin
                        d.mode  = MODE_RUN;
                        d.cnt   = '0;
                        d.pulse = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 8'd1;
                    end
                end
                MODE_RHOLD: begin
                    d.mode = MODE_STAB;
                    d.cnt  = '0;
                end
                default: begin
                    d.mode = MODE_RUN;
                    d.cnt  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode  <= MODE_RUN;
            q.cnt   <= '0;
            q.ack   <= 1'b0;
            q.pulse <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cpu_clk_en = (q.mode == MODE_RUN) || (q.mode == MODE_ARM);
    assign wake_pulse = q.pulse;
    assign ack_ok     = q.ack;
    assign clk_mode   = q.mode;

endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk
    import idle_wake_pkg::*;
#(
    parameter int N_RST    = 4,
    parameter int STAB_CYC = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pmode_sel,
    input logic             stop_wr,
    input logic [N_RST-1:0] rst_src,
    input logic             cpu_clk_en,
    input logic             wake_pulse,
    input logic             ack_ok,
    input logic [2:0]       clk_mode
);
    logic [15:0] stab_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stab_run <= '0;
        else if (clk_mode == MODE_STAB)
            stab_run <= (stab_run == 16'hFFFF) ? stab_run : stab_run + 16'd1;
        else
            stab_run <= '0;
    end

    // R5
    stab_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == MODE_RUN && $past(clk_mode) == MODE_STAB) |-> stab_run == 16'(STAB_CYC));

    // R5
    pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (cpu_clk_en && !$past(cpu_clk_en)));

    // R3
    idle_via_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == MODE_IDLE && $past(clk_mode) != MODE_IDLE) |-> $past(clk_mode) == MODE_ARM);

    // R2
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == MODE_RUN && stop_wr && pmode_sel[0]) |=> clk_mode != MODE_ARM);

    // R8
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rst_src) && $past(|rst_src)) |=> ##1 (clk_mode == MODE_RHOLD && !cpu_clk_en));

    // R8
    rst_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == MODE_RHOLD) |-> !ack_ok);

endmodule

bind idle_wake_ctrl idle_wake_chk #(.N_RST(N_RST), .STAB_CYC(STAB_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pmode_sel  (pmode_sel),
    .stop_wr    (stop_wr),
    .rst_src    (rst_src),
    .cpu_clk_en (cpu_clk_en),
    .wake_pulse (wake_pulse),
    .ack_ok     (ack_ok),
    .clk_mode   (clk_mode)
);

// File: tb/idle_wake_ctrl_tb.sv
module idle_wake_ctrl_tb;
    localparam int N   = 4;
    localparam int PW  = 3;
    localparam int NR  = 4;
    localparam int ENT = 5;
    localparam int STB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pmode_sel = 2'b00;
    logic          stop_wr = 1'b0;
    logic          nmi_req = 1'b0, nmi_blk = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N*PW-1:0] irq_prio = '1;
    logic          int_blk = 1'b0;
    logic          in_service = 1'b0;
    logic [PW-1:0] isr_prio = '0;
    logic [NR-1:0] rst_src = '0;
    logic          cpu_clk_en, wake_pulse, ack_ok;
    logic [2:0]    clk_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    idle_wake_ctrl #(.N_IRQ(N), .PRIO_W(PW), .N_RST(NR), .ENTRY_DLY(ENT), .STAB_CYC(STB)) u_dut (
        .clk(clk), .rst_n(rst_n), .pmode_sel(pmode_sel), .stop_wr(stop_wr),
        .nmi_req(nmi_req), .nmi_blk(nmi_blk), .irq_req(irq_req), .irq_prio(irq_prio),
        .int_blk(int_blk), .in_service(in_service), .isr_prio(isr_prio), .rst_src(rst_src),
        .cpu_clk_en(cpu_clk_en), .wake_pulse(wake_pulse), .ack_ok(ack_ok), .clk_mode(clk_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // R2 R3: accepted entry, sampled one cycle before and at the change
    task automatic enter_idle(input logic [1:0] sel);
        pmode_sel = sel;
        stop_wr = 1'b1;
        tick(1);
        stop_wr = 1'b0;
        chk("R3 padding mode", clk_mode, 1);
        tick(ENT - 1);
        chk("R3 clock still on", cpu_clk_en, 1);
        chk("R3 padding mode end", clk_mode, 1);
        tick(1);
        chk("R3 idle mode", clk_mode, 2);
        chk("R3 clock off", cpu_clk_en, 0);
    endtask

    // R5: request was driven just before; release is 3 + STB edges away
    task automatic release_check(input int exp_ack);
        tick(3 + STB - 1);
        chk("R5 still stabilizing", clk_mode, 3);
        chk("R5 clock off while stabilizing", cpu_clk_en, 0);
        tick(1);
        chk("R5 run mode", clk_mode, 0);
        chk("R5 clock back", cpu_clk_en, 1);
        chk("R5 wake pulse", wake_pulse, 1);
        chk("R6 ack", ack_ok, exp_ack);
        tick(1);
        chk("R5 pulse one cycle", wake_pulse, 0);
    endtask

    task automatic clear_reqs();
        irq_req = '0;
        nmi_req = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        chk("R1 mode", clk_mode, 0);
        chk("R1 clock", cpu_clk_en, 1);
        chk("R1 pulse", wake_pulse, 0);
        chk("R1 ack", ack_ok, 0);

        // R2: sweep every select value
        for (int s = 0; s < 4; s++) begin
            if (s[0]) begin
                pmode_sel = 2'(s);
                stop_wr = 1'b1;
                tick(1);
                stop_wr = 1'b0;
                chk("R2 rejected select", clk_mode, 0);
                tick(ENT + 3);
                chk("R2 rejected select later", clk_mode, 0);
                chk("R2 clock on", cpu_clk_en, 1);
            end else begin
                enter_idle(2'(s));
                nmi_req = 1'b1;            // R4 wake by non-maskable
                release_check(1);          // R6 non-maskable acks
                clear_reqs();
            end
        end

        // R4: blocked sources keep idle
        enter_idle(2'b00);
        int_blk = 1'b1;
        nmi_blk = 1'b1;
        irq_req = 4'b0100;
        nmi_req = 1'b1;
        tick(20);
        chk("R4 blocked stays idle", clk_mode, 2);
        chk("R4 blocked clock off", cpu_clk_en, 0);
        // R4: unblock maskable class, request already synchronized
        int_blk = 1'b0;
        tick(STB);
        chk("R4 unblock stabilizing", clk_mode, 3);
        tick(1);
        chk("R4 unblock run", clk_mode, 0);
        chk("R4 unblock pulse", wake_pulse, 1);
        chk("R6 no service ack", ack_ok, 1);
        nmi_blk = 1'b0;
        clear_reqs();

        // R9: ack held while running, cleared by next entry
        tick(10);
        chk("R9 ack held", ack_ok, 1);
        enter_idle(2'b10);
        chk("R9 ack cleared on entry", ack_ok, 0);
        irq_req = 4'b0001;
        release_check(1);
        clear_reqs();

        // R6: sweep request priority against in-service priority
        in_service = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 8; r++) begin
                isr_prio = 3'(p);
                irq_prio = '1;
                irq_prio[1*PW +: PW] = 3'(r);
                enter_idle(2'b00);
                irq_req = 4'b0010;
                release_check((r < p) ? 1 : 0);
                clear_reqs();
            end
        end

        // R6: most urgent of several active requests decides
        isr_prio = 3'd3;
        irq_prio = {3'd6, 3'd2, 3'd5, 3'd4};
        enter_idle(2'b00);
        irq_req = 4'b1111;
        release_check(1);
        clear_reqs();
        irq_prio = {3'd6, 3'd3, 3'd5, 3'd4};
        enter_idle(2'b00);
        irq_req = 4'b1111;
        release_check(0);
        clear_reqs();

        // R7: request pending before entry ends padding straight into run
        isr_prio = 3'd1;
        irq_prio = '1;
        irq_prio[2*PW +: PW] = 3'd0;
        irq_req = 4'b0100;
        tick(3);
        pmode_sel = 2'b00;
        stop_wr = 1'b1;
        tick(1);
        stop_wr = 1'b0;
        for (int k = 0; k < ENT; k++) begin
            chk("R7 clock never off", cpu_clk_en, 1);
            tick(1);
        end
        chk("R7 back in run", clk_mode, 0);
        chk("R7 clock on", cpu_clk_en, 1);
        chk("R7 ack", ack_ok, 1);
        chk("R7 no pulse", wake_pulse, 0);
        clear_reqs();
        in_service = 1'b0;

        // R8: reset source ends idle, beats a simultaneous interrupt
        enter_idle(2'b00);
        rst_src = 4'b0100;
        irq_req = 4'b0001;
        tick(2);
        chk("R8 not yet in hold", clk_mode, 2);
        tick(1);
        chk("R8 reset hold", clk_mode, 4);
        chk("R8 clock off", cpu_clk_en, 0);
        chk("R8 ack low", ack_ok, 0);
        irq_req = '0;
        tick(10);
        chk("R8 hold persists", clk_mode, 4);
        rst_src = '0;
        release_check(0);

        // R8: reset source while running
        tick(5);
        rst_src = 4'b1000;
        tick(3);
        chk("R8 hold from run", clk_mode, 4);
        chk("R8 clock off from run", cpu_clk_en, 0);
        rst_src = '0;
        release_check(0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule